// File: doc/BRIEF.md
# Source-Synchronous DAC Sample Port

This block takes 24-bit sample words from user logic and presents them to an external digital-to-analog converter at one quarter of the fast system clock rate (25 MHz from 100 MHz). The converter's sample clock is not a clock net. It is one more bit of the same output register that holds the 24 data bits. All 25 lines therefore leave through identical registering and change on the same fast edge. Board trace length then affects clock and data alike.

A divide-by-four phase sequencer makes every timing event. It raises a one-cycle ready strobe in the cycle before each data load. An incoming word is captured into a staging register when the strobe and the producer's valid are high together. The output register loads that word in the following phase. The sequencer also sets and clears the forwarded clock bit. The parameter `CLK_RISE_PHASE` (1 to 3) chooses how many fast cycles after the data update the converter's sampling edge occurs. The default of 2 places it 20 ns after the data change, in the middle of the 40 ns valid window.

Top module: `dac_srcsync_tx`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_data`, `dac_clk` and `s_ready` are all 0 after that edge.
- R2: `s_ready` is high for exactly one fast cycle in every four. Counting the first fast cycle after reset release as cycle 0, it is high in cycle n only when n mod 4 = 3 and n >= 7.
- R3: A word presented on `s_data` while `s_ready` and `s_valid` are both high in cycle n appears on `dac_data` from cycle n+2 on. It stays there until the next accepted word takes its place.
- R4: If `s_valid` is low while `s_ready` is high, `dac_data` keeps the previous word and `dac_clk` keeps toggling without change.
- R5: `dac_clk` has a period of four fast cycles and is high for two of them.
- R6: `dac_clk` is first high in cycle `CLK_RISE_PHASE`+1 after reset release. Each rising edge comes `CLK_RISE_PHASE` fast edges after the edge that updates `dac_data`.
- R7: `dac_data` changes only on the fast edge that ends phase 0 of the sequencer, so only into cycles n with n mod 4 = 1.
- R8: `dac_clk` falls two fast edges after it rises, modulo the four-phase cycle, for every legal `CLK_RISE_PHASE` from 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock, four times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Producer has a word on `s_data` |
| s_data | input | 24 | Sample word from user logic |
| s_ready | output | 1 | One-cycle strobe; a word is taken when this and `s_valid` are high |
| dac_data | output | 24 | Registered sample word to the converter |
| dac_clk | output | 1 | Forwarded sample clock, a bit of the output register |

## Verification
The acceptance strobe for the next word and the rising edge of the forwarded clock on the word already on the pins fall in the same fast cycle. Capture of the next word and the sampling edge on the current one therefore coincide. The bench drives dense, sparse and absent valid patterns with distinct data every cycle. In every cycle it compares the output word against a scoreboard queue filled only from accepted handshakes. It checks at the same time that the clock bit follows its own phase schedule. A wrong pairing of the capture and the load, or a clock bit that waits on data, shows as a word or clock mismatch.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    // Number of fast cycles per converter sample.
    localparam int unsigned PHASES_PER_SAMPLE = 4;

    // Phase at which the forwarded clock bit is cleared, half a period after it is set.
    function automatic int unsigned clk_fall_phase(input int unsigned rise_phase,
                                                   input int unsigned phases);
        return (rise_phase + phases / 2) % phases;
    endfunction

    // Phase counter value after one fast cycle.
    function automatic int unsigned next_phase(input int unsigned cur,
                                               input int unsigned phases);
        return (cur == phases - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/dac_phase_seq.sv
module dac_phase_seq
    import dac_tx_pkg::*;
#(
    parameter int unsigned DIV            = PHASES_PER_SAMPLE,
    parameter int unsigned CLK_RISE_PHASE = 2
) (
    input  logic clk,
    input  logic rst,
    output logic load_en,
    output logic ready,
    output logic clk_set,
    output logic clk_clr
);
    localparam int unsigned CW        = $clog2(DIV);
    localparam int unsigned FALL_PH   = clk_fall_phase(CLK_RISE_PHASE, DIV);
    localparam logic [CW-1:0] LAST_PH = CW'(DIV - 1);
    localparam logic [CW-1:0] RISE_PH = CW'(CLK_RISE_PHASE);
    localparam logic [CW-1:0] CLR_PH  = CW'(FALL_PH);

    typedef struct packed {
        logic [CW-1:0] ph;
        logic          armed;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = CW'(next_phase(int'(st_q.ph), DIV));
        if (st_q.ph == LAST_PH) begin
            st_d.armed = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_en = (st_q.ph == '0);
    assign ready   = st_q.armed && (st_q.ph == LAST_PH);
    assign clk_set = (st_q.ph == RISE_PH);
    assign clk_clr = (st_q.ph == CLR_PH);

    // R2: the strobe never lasts more than one fast cycle
    p_ready_single_r2: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R7: a load phase always follows the strobe
    p_load_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
        ready |=> load_en);

endmodule

// File: rtl/dac_word_capture.sv
module dac_word_capture #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ready,
    input  logic         valid,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic [W-1:0] word,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         pend;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (ready && valid) begin
            cap_d.word = din;
            cap_d.pend = 1'b1;
        end else if (take) begin
            cap_d.pend = 1'b0;
        end
        if (rst) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign word    = cap_q.word;
    assign pending = cap_q.pend;

    // R3: an accepted word is held in staging the next cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (ready && valid) |=> (pending && word == $past(din)));

    // R4: a strobe without valid leaves staging empty and untouched
    p_no_take_r4: assert property (@(posedge clk) disable iff (rst)
        (ready && !valid && !pending) |=> (!pending && $stable(word)));

endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         pending,
    input  logic [W-1:0] stage_word,
    input  logic         clk_set,
    input  logic         clk_clr,
    output logic [W-1:0] dac_data,
    output logic         dac_clk
);
    // Data and forwarded clock share one register so all lines launch together.
    typedef struct packed {
        logic         sclk;
        logic [W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load_en && pending) begin
            o_d.data = stage_word;
        end
        if (clk_set) begin
            o_d.sclk = 1'b1;
        end else if (clk_clr) begin
            o_d.sclk = 1'b0;
        end
        if (rst) begin
            o_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign dac_data = o_q.data;
    assign dac_clk  = o_q.sclk;

    // R1: reset clears every output line
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dac_data == '0 && !dac_clk));

    // R7: data only moves in the load phase
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(dac_data));

    // R3: a pending word reaches the pins at the load
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (load_en && pending) |=> (dac_data == $past(stage_word)));

    // R6: the set phase produces a high clock bit
    p_clk_rise_r6: assert property (@(posedge clk) disable iff (rst)
        clk_set |=> dac_clk);

    // R5: a rising clock bit holds for a second cycle
    p_clk_high_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_clk) |=> dac_clk);

    // R8: a falling clock bit holds low for a second cycle
    p_clk_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_clk) |=> !dac_clk);

endmodule

// File: rtl/dac_srcsync_tx.sv
module dac_srcsync_tx
    import dac_tx_pkg::*;
#(
    parameter int unsigned DATA_W         = 24,
    parameter int unsigned CLK_RISE_PHASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_clk
);
    localparam int unsigned DIV = PHASES_PER_SAMPLE;

    logic              load_en;
    logic              clk_set;
    logic              clk_clr;
    logic [DATA_W-1:0] stage_word;
    logic              stage_pend;

    dac_phase_seq #(
        .DIV            (DIV),
        .CLK_RISE_PHASE (CLK_RISE_PHASE)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .ready   (s_ready),
        .clk_set (clk_set),
        .clk_clr (clk_clr)
    );

    dac_word_capture #(
        .W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .ready   (s_ready),
        .valid   (s_valid),
        .take    (load_en),
        .din     (s_data),
        .word    (stage_word),
        .pending (stage_pend)
    );

    dac_out_reg #(
        .W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .pending    (stage_pend),
        .stage_word (stage_word),
        .clk_set    (clk_set),
        .clk_clr    (clk_clr),
        .dac_data   (dac_data),
        .dac_clk    (dac_clk)
    );

    // R1: reset silences the strobe
    p_ready_reset_r1: assert property (@(posedge clk)
        rst |=> !s_ready);

    // R4: the forwarded clock keeps moving when no word is offered
    p_clk_free_r4: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid && $past(dac_clk) && dac_clk) |=> !dac_clk);

endmodule

// File: tb/dac_srcsync_tx_tb.sv
module dac_srcsync_tx_tb;
    localparam int W    = 24;
    localparam int RISE = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         s_ready;
    logic [W-1:0] dac_data;
    logic         dac_clk;

    int compared   = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    dac_srcsync_tx #(.DATA_W(W), .CLK_RISE_PHASE(RISE)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_ready  (s_ready),
        .dac_data (dac_data),
        .dac_clk  (dac_clk)
    );

    // scoreboard queues: word and sample index at which it must show
    logic [W-1:0] q_word[$];
    int           q_due[$];
    logic [W-1:0] cur_exp = '0;
    int           n = 0;
    logic         rst_prev = 1'b0;
    logic         done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at sample %0d: actual %h expected %h", req, n, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            if (rst_prev) begin
                check(dac_data == '0 && !dac_clk && !s_ready, "R1 reset state",
                      {dac_clk, s_ready, dac_data[W-3:0]}, '0);
            end
            n = 0;
            q_word.delete();
            q_due.delete();
            cur_exp = '0;
        end else begin
            bit exp_rdy;
            bit exp_clk;
            exp_rdy = (n % 4 == 3) && (n >= 7);
            exp_clk = (n >= RISE + 1) && (((n - (RISE + 1)) % 4) < 2);
            if (q_due.size() > 0 && q_due[0] == n) begin
                cur_exp = q_word.pop_front();
                void'(q_due.pop_front());
            end
            check(s_ready == exp_rdy, "R2 ready strobe", W'(s_ready), W'(exp_rdy));
            check(dac_clk == exp_clk, "R5 R6 R8 forwarded clock", W'(dac_clk), W'(exp_clk));
            check(dac_data == cur_exp, "R3 R4 R7 data word", dac_data, cur_exp);
            if (s_ready && s_valid) begin
                q_word.push_back(s_data);
                q_due.push_back(n + 2);
            end
            n++;
        end
        rst_prev = rst;
    end

    // driver
    logic [W-1:0] lfsr = 24'hA5C3E1;

    task automatic step_lfsr();
        lfsr = {lfsr[W-2:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
    endtask

    // mode 0: valid always, 1: valid pseudo-random, 2: valid never, 3: walking ones
    task automatic drive(input int cycles, input int mode);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            step_lfsr();
            case (mode)
                0: begin s_valid = 1'b1; s_data = lfsr; end
                1: begin s_valid = lfsr[3]; s_data = ~lfsr; end
                2: begin s_valid = 1'b0; s_data = lfsr; end
                default: begin s_valid = 1'b1; s_data = W'(1) << (i % W); end
            endcase
        end
    endtask

    task automatic do_reset(input int cycles);
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (cycles) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        do_reset(4);
        drive(60, 0);
        drive(80, 1);
        drive(40, 2);
        drive(120, 3);
        // all-ones then all-zeros words
        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            #1 s_valid = 1'b1;
            s_data = (i < 8) ? '1 : '0;
        end
        do_reset(3);
        drive(100, 1);
        drive(40, 0);
        repeat (4) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule